// File: doc/BRIEF.md
# Dual-Channel Sampling Converter Serial Port Emulator

This block models the digital side of a dual-channel 12-bit sampling converter. A host pulls the active-low chip select low to start a conversion. It then toggles the serial clock and reads one result word per line, or both results from a single line in a 32-clock frame. Both serial clock and chip select are taken as plain inputs in a fast system clock domain. Their edges are found by comparing each input with its value one system clock earlier.

The block also follows the converter's power state: normal, partial power-down or full power-down. The only thing that sets the state is how many serial clock falling edges have been counted when chip select rises. The same window has a different meaning in each state. A flag marks the frames whose data would not be valid on real silicon, such as the dummy conversion that wakes the part and, after waking from full power-down, one more frame.

Top module: `adc_port_emu`

## Requirements
- R1: After reset, powerState is 0 (normal), both line enables are 0 and dataValid is 0. The powerState encoding is 0 normal, 1 partial power-down, 2 full power-down.
- R2: The system clock cycle in which csN is first seen low starts a frame. Both line enables rise, and sampleA and sampleB are captured in that cycle. Later changes to the sample inputs do not affect the frame.
- R3: Let k be the number of sclk falling edges counted since the frame started, with k = 0 straight after the start. Line A then shows 0 for k in {0,1,14..17,30,31}, sampleA bit (13-k) for k = 2..13, and sampleB bit (29-k) for k = 18..29. Line B shows the same pattern with the two channels swapped.
- R4: Once the frame has started, the line enables stay high past the 14th edge and fall in the cycle that follows the sampling of csN high, whatever k is. An sclk falling edge seen in the same cycle as that csN rise is not counted.
- R5: The 32nd sclk falling edge releases both lines while csN is still low. Later edges change nothing until csN rises.
- R6: In normal state, a csN rise with k < 2 leaves the state normal.
- R7: In normal state, a csN rise with 2 <= k <= 9 moves the block to partial power-down.
- R8: In normal state, a csN rise with k >= 10 leaves the state normal.
- R9: In partial power-down, a csN rise with k < 2 keeps partial power-down, 2 <= k <= 9 moves to full power-down, and k >= 10 returns to normal.
- R10: In full power-down, a csN rise with k <= 9 keeps full power-down, and k >= 10 returns to normal.
- R11: dataValid is updated when a frame starts and holds until the next frame starts. It is 1 only if the frame starts in normal state and is not the first frame after a wake from full power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low, sampled on clk |
| sclk | input | 1 | Serial clock, sampled on clk |
| sampleA | input | 12 | Channel A result to send |
| sampleB | input | 12 | Channel B result to send |
| sdoA | output | 1 | Serial data line A |
| sdoAEn | output | 1 | Drive enable for line A (0 = three-state) |
| sdoB | output | 1 | Serial data line B |
| sdoBEn | output | 1 | Drive enable for line B (0 = three-state) |
| powerState | output | 2 | Current power state |
| dataValid | output | 1 | The current frame carries valid data |

## Verification
The hardest case to reach is the invalid frame that follows a wake from full power-down. To get there the block must first go from normal to partial power-down, then to full power-down, then take a dummy conversion of ten or more edges, and only then start the next frame. The bench runs that chain as a directed sequence and probes the edge counts 1, 2, 9 and 10 at each state. Random frames then use edge counts from 0 to 34, so the transitions also happen in orders nobody planned. An independent model predicts every data bit, every enable and every state.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  typedef enum logic [1:0] {
    PWR_NORMAL  = 2'd0,
    PWR_PARTIAL = 2'd1,
    PWR_FULL    = 2'd2
  } pwr_state_t;

  typedef struct packed {
    logic load;     // frame start: capture samples, drive lines
    logic advance;  // next bit onto the lines
    logic release_; // three-state both lines
  } ctrl_strobe_t;
endpackage

// File: rtl/adc_port_ctrl.sv
module adc_port_ctrl
  import adc_port_pkg::*;
#(
  parameter int FRAME_EDGES = 32,
  parameter int SLEEP_EDGE  = 2,
  parameter int WAKE_EDGE   = 10,
  parameter int EXTRA_BAD   = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         sclk,
  output ctrl_strobe_t strobe,
  output pwr_state_t   powerState,
  output logic         dataValid
);
  localparam int CW = $clog2(FRAME_EDGES + 1);
  localparam int PW = $clog2(EXTRA_BAD + 1) + 1;

  logic          csPrev, sclkPrev;
  logic          csFall, csRise, sclkFall;
  logic          frameActive;
  logic [CW-1:0] edgeCount;
  logic [PW-1:0] badLeft;
  pwr_state_t    state, nextState;

  assign csFall   = csPrev & ~csN;
  assign csRise   = ~csPrev & csN;
  assign sclkFall = sclkPrev & ~sclk;

  assign strobe.load     = csFall;
  assign strobe.advance  = frameActive && sclkFall && !csRise &&
                           (edgeCount < CW'(FRAME_EDGES));
  assign strobe.release_ = (frameActive && csRise) ||
                           (strobe.advance && edgeCount == CW'(FRAME_EDGES - 1));

  always_comb begin
    nextState = state;
    if (edgeCount >= CW'(WAKE_EDGE)) begin
      nextState = PWR_NORMAL;
    end else if (edgeCount >= CW'(SLEEP_EDGE)) begin
      case (state)
        PWR_NORMAL:  nextState = PWR_PARTIAL;
        default:     nextState = PWR_FULL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev      <= 1'b1;
      sclkPrev    <= 1'b0;
      frameActive <= 1'b0;
      edgeCount   <= '0;
      state       <= PWR_NORMAL;
      badLeft     <= '0;
      dataValid   <= 1'b0;
    end else begin
      csPrev   <= csN;
      sclkPrev <= sclk;
      if (csFall) begin
        frameActive <= 1'b1;
        edgeCount   <= '0;
        dataValid   <= (state == PWR_NORMAL) && (badLeft == '0);
        if (state == PWR_NORMAL && badLeft != '0) badLeft <= badLeft - 1'b1;
      end else if (frameActive && csRise) begin
        frameActive <= 1'b0;
        state       <= nextState;
        if (state == PWR_FULL && nextState == PWR_NORMAL) badLeft <= PW'(EXTRA_BAD);
      end else if (strobe.advance) begin
        edgeCount <= edgeCount + 1'b1;
      end
    end
  end

  assign powerState = state;

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    edgeCount <= CW'(FRAME_EDGES));
  assert_cs_high_ends_R4: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !frameActive);
  assert_no_skip_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(state) == PWR_NORMAL |-> state != PWR_FULL);
  assert_valid_normal_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> $past(state) == PWR_NORMAL);
  assert_full_wake_bad_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == PWR_FULL && state == PWR_NORMAL) |-> badLeft == PW'(EXTRA_BAD));
endmodule

// File: rtl/adc_port_data.sv
module adc_port_data
  import adc_port_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int LEAD_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [DATA_W-1:0] sampleA,
  input  logic [DATA_W-1:0] sampleB,
  output logic              sdoA,
  output logic              sdoAEn,
  output logic              sdoB,
  output logic              sdoBEn
);
  localparam int HALF_W  = 2 * LEAD_W + DATA_W;
  localparam int FRAME_W = 2 * HALF_W;

  logic [FRAME_W-1:0] wordA, wordB;
  logic               driveEn;

  function automatic logic [FRAME_W-1:0] buildFrame(
      input logic [DATA_W-1:0] first, input logic [DATA_W-1:0] second);
    return {{LEAD_W{1'b0}}, first, {(2*LEAD_W){1'b0}}, second, {LEAD_W{1'b0}}};
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordA   <= '0;
      wordB   <= '0;
      driveEn <= 1'b0;
    end else if (strobe.load) begin
      wordA   <= buildFrame(sampleA, sampleB);
      wordB   <= buildFrame(sampleB, sampleA);
      driveEn <= 1'b1;
    end else begin
      if (strobe.advance) begin
        wordA <= {wordA[FRAME_W-2:0], 1'b0};
        wordB <= {wordB[FRAME_W-2:0], 1'b0};
      end
      if (strobe.release_) driveEn <= 1'b0;
    end
  end

  assign sdoA   = driveEn & wordA[FRAME_W-1];
  assign sdoB   = driveEn & wordB[FRAME_W-1];
  assign sdoAEn = driveEn;
  assign sdoBEn = driveEn;

  assert_load_drives_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> driveEn);
  assert_release_tristates_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.release_ && !strobe.load) |=> !driveEn);
endmodule

// File: rtl/adc_port_emu.sv
module adc_port_emu
  import adc_port_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int LEAD_W     = 2,
  parameter int SLEEP_EDGE = 2,
  parameter int WAKE_EDGE  = 10,
  parameter int EXTRA_BAD  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sampleA,
  input  logic [DATA_W-1:0] sampleB,
  output logic              sdoA,
  output logic              sdoAEn,
  output logic              sdoB,
  output logic              sdoBEn,
  output logic [1:0]        powerState,
  output logic              dataValid
);
  localparam int FRAME_EDGES = 2 * (2 * LEAD_W + DATA_W);

  ctrl_strobe_t strobe;
  pwr_state_t   stateInt;

  adc_port_ctrl #(
    .FRAME_EDGES(FRAME_EDGES), .SLEEP_EDGE(SLEEP_EDGE),
    .WAKE_EDGE(WAKE_EDGE), .EXTRA_BAD(EXTRA_BAD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk),
    .strobe(strobe), .powerState(stateInt), .dataValid(dataValid)
  );

  adc_port_data #(.DATA_W(DATA_W), .LEAD_W(LEAD_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sampleA(sampleA), .sampleB(sampleB),
    .sdoA(sdoA), .sdoAEn(sdoAEn), .sdoB(sdoB), .sdoBEn(sdoBEn)
  );

  assign powerState = stateInt;
endmodule

// File: tb/adc_port_emu_test.sv
module adc_port_emu_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic [11:0] sampleA = '0, sampleB = '0;
  logic sdoA, sdoAEn, sdoB, sdoBEn, dataValid;
  logic [1:0] powerState;

  int errors = 0;
  int checks = 0;
  int mState = 0;   // model: 0 normal, 1 partial, 2 full
  int mBad = 0;
  logic mValid = 1'b0;

  always #2 clk = ~clk;

  adc_port_emu uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk),
    .sampleA(sampleA), .sampleB(sampleB),
    .sdoA(sdoA), .sdoAEn(sdoAEn), .sdoB(sdoB), .sdoBEn(sdoBEn),
    .powerState(powerState), .dataValid(dataValid)
  );

  function automatic logic expBit(int k, logic [11:0] first, logic [11:0] second);
    if (k >= 2 && k <= 13) return first[13-k];
    if (k >= 18 && k <= 29) return second[29-k];
    return 1'b0;
  endfunction

  function automatic int nextState(int st, int n);
    if (n >= 10) return 0;
    if (n < 2) return st;
    return (st == 0) ? 1 : 2;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic runFrame(int n, logic [11:0] a, logic [11:0] b);
    int st;
    @(negedge clk); csN = 1'b0; sampleA = a; sampleB = b;
    mValid = (mState == 0) && (mBad == 0);
    if (mState == 0 && mBad > 0) mBad--;
    step();
    check(sdoAEn && sdoBEn, "R2 enables", {sdoAEn, sdoBEn}, 3);
    check(dataValid == mValid, "R11 valid", dataValid, mValid);
    check(sdoA == expBit(0, a, b) && sdoB == expBit(0, b, a), "R3 bit0",
          {sdoA, sdoB}, {expBit(0, a, b), expBit(0, b, a)});
    @(negedge clk); sampleA = ~a; sampleB = ~b;  // R2: captured, no effect
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); sclk = 1'b1;
      @(negedge clk); sclk = 1'b0;
      step();
      if (i < 32) begin
        check(sdoAEn && sdoBEn, "R4 held", {sdoAEn, sdoBEn}, 3);
        check(sdoA == expBit(i, a, b) && sdoB == expBit(i, b, a), "R3 bits",
              {sdoA, sdoB}, {expBit(i, a, b), expBit(i, b, a)});
      end else begin
        check(!sdoAEn && !sdoBEn && !sdoA && !sdoB, "R5 released",
              {sdoAEn, sdoBEn, sdoA, sdoB}, 0);
      end
    end
    @(negedge clk); csN = 1'b1;
    st = mState;
    mState = nextState(mState, n);
    step();
    check(!sdoAEn && !sdoBEn, "R4 cs release", {sdoAEn, sdoBEn}, 0);
    if (st == 0) begin
      if (n < 2) check(powerState == 2'(mState), "R6 glitch", powerState, mState);
      else if (n < 10) check(powerState == 2'(mState), "R7 sleep", powerState, mState);
      else check(powerState == 2'(mState), "R8 stay", powerState, mState);
    end else if (st == 1) begin
      check(powerState == 2'(mState), "R9 partial", powerState, mState);
    end else begin
      check(powerState == 2'(mState), "R10 full", powerState, mState);
    end
    if (st == 2 && mState == 0) mBad = 1;
    check(dataValid == mValid, "R11 hold", dataValid, mValid);
  endtask

  // R4: sclk fall coincident with csN rise is not counted (9 edges + 1 coincident)
  task automatic coincidentFrame();
    @(negedge clk); csN = 1'b0; sampleA = 12'hA5A; sampleB = 12'h5A5;
    mValid = (mState == 0) && (mBad == 0);
    if (mState == 0 && mBad > 0) mBad--;
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk); sclk = 1'b1;
      @(negedge clk); sclk = 1'b0;
    end
    @(negedge clk); sclk = 1'b1;
    @(negedge clk); sclk = 1'b0; csN = 1'b1;
    mState = nextState(mState, 9);
    step();
    check(powerState == 2'(mState), "R4 coincident edge", powerState, mState);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check(powerState == 0 && !sdoAEn && !sdoBEn && !dataValid, "R1 reset",
          {powerState, sdoAEn, sdoBEn, dataValid}, 0);
    @(negedge clk); rstN = 1'b1;
    step();
    check(powerState == 0 && !sdoAEn && !dataValid, "R1 after reset",
          {powerState, sdoAEn, dataValid}, 0);
    // R5: sclk toggling with csN high does nothing
    @(negedge clk); sclk = 1'b1; @(negedge clk); sclk = 1'b0; step();
    check(!sdoAEn && !sdoBEn, "R5 idle", {sdoAEn, sdoBEn}, 0);
    // directed chain
    runFrame(14, 12'hFFF, 12'h001);   // R8 full-length read, valid
    runFrame(1, 12'h800, 12'h7FF);    // R6 glitch stays normal
    runFrame(34, 12'hABC, 12'h123);   // R5 dual read + release
    runFrame(2, 12'h111, 12'h222);    // R7 to partial
    runFrame(1, 12'h333, 12'h444);    // R9 glitch stays partial
    runFrame(10, 12'h555, 12'h666);   // R9 wake to normal
    runFrame(16, 12'h777, 12'h888);   // R11 valid after partial wake
    runFrame(9, 12'h999, 12'hAAA);    // R7 to partial
    runFrame(5, 12'hBBB, 12'hCCC);    // R9 to full
    runFrame(1, 12'hDDD, 12'hEEE);    // R10 glitch stays full
    runFrame(9, 12'h0F0, 12'hF0F);    // R10 window stays full
    runFrame(10, 12'h135, 12'h246);   // R10 wake, dummy invalid
    runFrame(14, 12'h357, 12'h468);   // R11 extra invalid frame
    runFrame(14, 12'h579, 12'h68A);   // R11 valid again
    coincidentFrame();
    for (int r = 0; r < 40; r++) begin
      n = $urandom_range(0, 34);
      if (r % 3 == 0) n = $urandom_range(1, 11);
      runFrame(n, 12'($urandom), 12'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule